// File: doc/BRIEF.md
# Audio Bit and Frame Clock Divider

This block turns a master audio clock into the two serial-audio timing clocks: a bit clock and a frame (word-select) clock. The bit clock is the master clock divided by 2 or 4. The frame clock is the bit clock divided by 32, 64 or 128. All outputs are registers in the master clock domain, so the two clocks and the bit-clock edge strobes stay phase-locked to one another.

Normally the dividers come from a requested master-clock-to-sample-rate ratio. The block compares that ratio against two midpoint thresholds rather than dividing exactly, and always keeps the frame divider at 64 or more. A three-bit override code can force any legal pair of dividers. A code whose low two bits are zero is not a legal override, and the automatic choice is used instead.

The ratio and the override are captured once, when the block is enabled. They are then held until the block is disabled. While disabled, every output is held low. On enable, both clocks start from that low level in phase.

Top module: `audio_clk_ratio_gen`

## Requirements
- R1: While `rst_ni` is low, `bclk_o`, `fclk_o`, `bclk_rise_o` and `bclk_fall_o` are all 0, whatever `en_i` is.
- R2: While running, `bclk_o` is a 50% duty clock with a period of BD master cycles, where BD is the selected bit divider (2 or 4).
- R3: In automatic mode, a ratio strictly greater than 384 selects BD = 4 and frame divider FD = 128.
- R4: In automatic mode, a ratio of 384 or less selects FD = 64. BD is 2 when the ratio is below 192, and 4 from 192 upward.
- R5: `fclk_o` starts low and toggles only in the master cycle in which `bclk_o` falls. It toggles after every FD/2 bit-clock falls, which gives a frame period of FD bit clocks.
- R6: `bclk_rise_o` (`bclk_fall_o`) is high for exactly the master cycles in which `bclk_o` has just gone from 0 to 1 (from 1 to 0). The two strobes are never high together.
- R7: At the first clock edge at which `en_i` is low, all four outputs go to 0, and they stay at 0 while `en_i` stays low.
- R8: Take the first edge at which `en_i` is high while the block is stopped, and count edges j = 0, 1, ... from it. After edge j, the expected outputs are `bclk_o` = (j / (BD/2)) mod 2 and `fclk_o` = (j / (BD*FD/2)) mod 2, using integer division.
- R9: When `ovr_i[1:0]` is nonzero, it forces the dividers. `ovr_i[2]` = 0 gives BD = 2 and 1 gives BD = 4. `ovr_i[1:0]` = 1, 2 or 3 gives FD = 32, 64 or 128.
- R10: An override code with `ovr_i[1:0]` = 0 (that is, 0 or 4) is ignored, and the automatic selection of R3 and R4 applies.
- R11: `ratio_i` and `ovr_i` are sampled only on the enabling edge of R8. Changing them while running has no effect on either output clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master audio clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds all outputs at 0 |
| ratio_i | input | RATIO_W (12) | Requested master-clock to sample-rate ratio |
| ovr_i | input | 3 | Divider override code (R9, R10) |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock, low for the first half-frame |
| bclk_rise_o | output | 1 | Strobe: bit clock has just risen |
| bclk_fall_o | output | 1 | Strobe: bit clock has just fallen |

## Verification
The bench probes the threshold edges of the automatic selection: ratios 191, 192, 384 and 385, plus the extremes 0 and 4095. A design that used a non-strict or off-by-one compare would give the wrong bit period or frame length at exactly one of these values.

Every legal override code and both illegal codes are run. A design that trusted the code's high bit alone would produce a frame divider of zero or a stray frame length.

Each configuration is compared cycle by cycle against the arithmetic model of R8 over two full frames. This catches a first edge that comes one master cycle late, a frame toggle taken on the rising bit-clock edge, and strobes that are misplaced.

Halfway through each run, the ratio and override inputs are changed. A block that resampled them would visibly change period. Disabling after each run checks that the outputs collapse to zero on the first disabled edge.

// File: rtl/aclk_ratio_pkg.sv
package aclk_ratio_pkg;

  localparam int unsigned BDIV_MAX    = 4;
  localparam int unsigned FDIV_MAX    = 128;
  localparam int unsigned HALF_B_MAX  = BDIV_MAX / 2;
  localparam int unsigned HALF_F_MAX  = FDIV_MAX / 2;
  localparam int unsigned HCNT_W      = (HALF_B_MAX > 1) ? $clog2(HALF_B_MAX) : 1;
  localparam int unsigned FCNT_W      = (HALF_F_MAX > 1) ? $clog2(HALF_F_MAX) : 1;

  // automatic thresholds are midpoints between neighbouring ratio classes
  localparam int unsigned THR_HI_DEF  = (256 + 512) / 2;
  localparam int unsigned THR_LO_DEF  = (128 + 256) / 2;

  typedef enum logic {
    BDIV_2 = 1'b0,
    BDIV_4 = 1'b1
  } bdiv_e;

  typedef enum logic [1:0] {
    FDIV_NONE = 2'd0,
    FDIV_32   = 2'd1,
    FDIV_64   = 2'd2,
    FDIV_128  = 2'd3
  } fdiv_e;

  typedef struct packed {
    bdiv_e bdiv;
    fdiv_e fdiv;
  } clk_cfg_t;

  localparam clk_cfg_t CFG_RESET = '{bdiv: BDIV_2, fdiv: FDIV_64};

  // last value of the master-cycle counter within one bit-clock half period
  function automatic logic [HCNT_W-1:0] bit_half_last(input bdiv_e b);
    int unsigned half;
    half = (b == BDIV_4) ? (BDIV_MAX / 2) : (BDIV_MAX / 4);
    return HCNT_W'(half - 1);
  endfunction

  // last value of the bit-clock fall counter within one half frame
  function automatic logic [FCNT_W-1:0] frame_half_last(input fdiv_e f);
    int unsigned full;
    full = FDIV_MAX >> (3 - int'(f));
    return FCNT_W'((full / 2) - 1);
  endfunction

endpackage

// File: rtl/aclk_ratio_select.sv
module aclk_ratio_select
  import aclk_ratio_pkg::*;
#(
  parameter int unsigned RATIO_W = 12,
  parameter int unsigned THR_HI  = THR_HI_DEF,
  parameter int unsigned THR_LO  = THR_LO_DEF,
  parameter bit          OVR_EN  = 1'b1
) (
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [2:0]         ovr_i,
  output clk_cfg_t           cfg_o
);

  localparam logic [RATIO_W-1:0] HI_V = RATIO_W'(THR_HI);
  localparam logic [RATIO_W-1:0] LO_V = RATIO_W'(THR_LO);

  clk_cfg_t auto_cfg;
  logic     above_hi;
  logic     below_lo;

  always_comb begin
    above_hi = (ratio_i > HI_V);
    below_lo = (ratio_i < LO_V);
    if (above_hi) begin
      auto_cfg.bdiv = BDIV_4;
      auto_cfg.fdiv = FDIV_128;
    end else if (below_lo) begin
      auto_cfg.bdiv = BDIV_2;
      auto_cfg.fdiv = FDIV_64;
    end else begin
      auto_cfg.bdiv = BDIV_4;
      auto_cfg.fdiv = FDIV_64;
    end
  end

  generate
    if (OVR_EN) begin : g_ovr
      logic ovr_legal;
      always_comb begin
        ovr_legal = (ovr_i[1:0] != 2'd0);
        if (ovr_legal) begin
          cfg_o.bdiv = bdiv_e'(ovr_i[2]);
          cfg_o.fdiv = fdiv_e'(ovr_i[1:0]);
        end else begin
          cfg_o = auto_cfg;
        end
      end
    end else begin : g_auto
      logic [2:0] ovr_unused;
      assign ovr_unused = ovr_i;
      always_comb cfg_o = auto_cfg;
    end
  endgenerate

  // R3/R4/R9/R10: the selection never yields an illegal frame divider
  always_comb begin
    a_r9_fdiv_legal: assert (cfg_o.fdiv != FDIV_NONE);
  end

endmodule

// File: rtl/aclk_bclk_div.sv
module aclk_bclk_div
  import aclk_ratio_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  act_i,
  input  bdiv_e bdiv_i,
  output logic  bclk_o,
  output logic  rise_o,
  output logic  fall_o,
  output logic  fall_now_o
);

  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  logic              bclk_q, bclk_d;
  logic              rise_q, rise_d;
  logic              fall_q, fall_d;
  logic              tick;

  always_comb begin
    tick       = act_i && (hcnt_q == bit_half_last(bdiv_i));
    fall_now_o = tick && bclk_q;
    hcnt_d     = hcnt_q;
    bclk_d     = bclk_q;
    rise_d     = 1'b0;
    fall_d     = 1'b0;
    if (!act_i) begin
      hcnt_d = '0;
      bclk_d = 1'b0;
    end else if (tick) begin
      hcnt_d = '0;
      bclk_d = !bclk_q;
      rise_d = !bclk_q;
      fall_d = bclk_q;
    end else begin
      hcnt_d = hcnt_q + HCNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      bclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      bclk_q <= bclk_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign bclk_o = bclk_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  a_r6_rise_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> (bclk_q && !$past(bclk_q)));

  a_r6_fall_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q |-> (!bclk_q && $past(bclk_q)));

endmodule

// File: rtl/aclk_frame_div.sv
module aclk_frame_div
  import aclk_ratio_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  act_i,
  input  logic  fall_now_i,
  input  fdiv_e fdiv_i,
  output logic  fclk_o
);

  logic [FCNT_W-1:0] fcnt_q, fcnt_d;
  logic              fclk_q, fclk_d;
  logic              step;
  logic              wrap;

  always_comb begin
    step   = act_i && fall_now_i;
    wrap   = (fcnt_q == frame_half_last(fdiv_i));
    fcnt_d = fcnt_q;
    fclk_d = fclk_q;
    if (!act_i) begin
      fcnt_d = '0;
      fclk_d = 1'b0;
    end else if (step) begin
      if (wrap) begin
        fcnt_d = '0;
        fclk_d = !fclk_q;
      end else begin
        fcnt_d = fcnt_q + FCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
      fclk_q <= 1'b0;
    end else begin
      fcnt_q <= fcnt_d;
      fclk_q <= fclk_d;
    end
  end

  assign fclk_o = fclk_q;

  a_r5_frame_on_bit_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fclk_q != $past(fclk_q)) |-> ($past(fall_now_i) || !$past(act_i)));

endmodule

// File: rtl/audio_clk_ratio_gen.sv
module audio_clk_ratio_gen
  import aclk_ratio_pkg::*;
#(
  parameter int unsigned RATIO_W = 12,
  parameter int unsigned THR_HI  = THR_HI_DEF,
  parameter int unsigned THR_LO  = THR_LO_DEF,
  parameter bit          OVR_EN  = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [2:0]         ovr_i,
  output logic               bclk_o,
  output logic               fclk_o,
  output logic               bclk_rise_o,
  output logic               bclk_fall_o
);

  clk_cfg_t sel_cfg;
  clk_cfg_t cfg_q, cfg_d;
  logic     run_q, run_d;
  logic     act;
  logic     fall_now;

  aclk_ratio_select #(
    .RATIO_W (RATIO_W),
    .THR_HI  (THR_HI),
    .THR_LO  (THR_LO),
    .OVR_EN  (OVR_EN)
  ) u_select (
    .ratio_i (ratio_i),
    .ovr_i   (ovr_i),
    .cfg_o   (sel_cfg)
  );

  always_comb begin
    run_d = en_i;
    cfg_d = cfg_q;
    if (en_i && !run_q) begin
      cfg_d = sel_cfg;
    end
    act = en_i && run_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cfg_q <= CFG_RESET;
    end else begin
      run_q <= run_d;
      cfg_q <= cfg_d;
    end
  end

  aclk_bclk_div u_bclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .bdiv_i     (cfg_q.bdiv),
    .bclk_o     (bclk_o),
    .rise_o     (bclk_rise_o),
    .fall_o     (bclk_fall_o),
    .fall_now_o (fall_now)
  );

  aclk_frame_div u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .fall_now_i (fall_now),
    .fdiv_i     (cfg_q.fdiv),
    .fclk_o     (fclk_o)
  );

  a_r7_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!bclk_o && !fclk_o && !bclk_rise_o && !bclk_fall_o));

  a_r8_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (!bclk_o && !fclk_o));

  a_r11_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && $past(act)) |-> (cfg_q == $past(cfg_q)));

  a_r6_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bclk_rise_o, bclk_fall_o}));

endmodule

// File: tb/audio_clk_ratio_gen_test.sv
module audio_clk_ratio_gen_test;

  logic        clk_i;
  logic        rst_ni;
  logic        en_i;
  logic [11:0] ratio_i;
  logic [2:0]  ovr_i;
  logic        bclk_o;
  logic        fclk_o;
  logic        bclk_rise_o;
  logic        bclk_fall_o;

  int checks;
  int errors;
  int cycles;

  audio_clk_ratio_gen uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .ratio_i     (ratio_i),
    .ovr_i       (ovr_i),
    .bclk_o      (bclk_o),
    .fclk_o      (fclk_o),
    .bclk_rise_o (bclk_rise_o),
    .bclk_fall_o (bclk_fall_o)
  );

  initial clk_i = 1'b0;
  always #4 clk_i = !clk_i;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: run still active after %0d cycles, expected completion", cycles);
        finish_run();
      end
    end
  end

  // expected dividers from R3, R4, R9, R10
  task automatic expect_cfg(input int ratio, input int ovr, output int bd, output int fd);
    if ((ovr % 4) != 0) begin
      bd = (ovr >= 4) ? 4 : 2;
      fd = 16 << (ovr % 4);
    end else if (ratio > 384) begin
      bd = 4; fd = 128;
    end else if (ratio < 192) begin
      bd = 2; fd = 64;
    end else begin
      bd = 4; fd = 64;
    end
  endtask

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic run_cfg(input int ratio, input int ovr, input string req);
    int bd, fd, h, len, alt;
    int bad_b, bad_f, bad_r, bad_l;
    string first_b, first_f, first_r, first_l;
    expect_cfg(ratio, ovr, bd, fd);
    h   = bd / 2;
    len = 2 * bd * fd + 6;
    alt = (ratio > 384) ? 100 : 1000;
    bad_b = 0; bad_f = 0; bad_r = 0; bad_l = 0;
    first_b = ""; first_f = ""; first_r = ""; first_l = "";

    // R7: idle level while disabled
    en_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check_bit("R7", "idle outputs", bclk_o | fclk_o | bclk_rise_o | bclk_fall_o, 1'b0);

    ratio_i = 12'(ratio);
    ovr_i   = 3'(ovr);
    en_i    = 1'b1;
    for (int j = 0; j <= len; j++) begin
      logic eb, ef, er, el;
      @(negedge clk_i);
      eb = 1'((j / h) % 2);
      ef = 1'((j / (bd * fd / 2)) % 2);
      er = (j > 0) && (j % h == 0) && ((j / h) % 2 == 1);
      el = (j > 0) && (j % bd == 0);
      if (bclk_o !== eb) begin
        if (bad_b == 0) first_b = $sformatf("j=%0d actual=%b expected=%b", j, bclk_o, eb);
        bad_b++;
      end
      if (fclk_o !== ef) begin
        if (bad_f == 0) first_f = $sformatf("j=%0d actual=%b expected=%b", j, fclk_o, ef);
        bad_f++;
      end
      if (bclk_rise_o !== er) begin
        if (bad_r == 0) first_r = $sformatf("j=%0d actual=%b expected=%b", j, bclk_rise_o, er);
        bad_r++;
      end
      if (bclk_fall_o !== el) begin
        if (bad_l == 0) first_l = $sformatf("j=%0d actual=%b expected=%b", j, bclk_fall_o, el);
        bad_l++;
      end
      // R11: change the selection inputs mid-run; must be ignored
      if (j == len / 2) begin
        ratio_i = 12'(alt);
        ovr_i   = 3'd0;
      end
    end
    checks += 4;
    if (bad_b != 0) begin
      errors++;
      $display("FAIL %s R2 R8 R11 bclk (ratio=%0d ovr=%0d) %s", req, ratio, ovr, first_b);
    end
    if (bad_f != 0) begin
      errors++;
      $display("FAIL %s R5 R8 R11 fclk (ratio=%0d ovr=%0d) %s", req, ratio, ovr, first_f);
    end
    if (bad_r != 0) begin
      errors++;
      $display("FAIL R6 rise strobe (ratio=%0d ovr=%0d) %s", ratio, ovr, first_r);
    end
    if (bad_l != 0) begin
      errors++;
      $display("FAIL R6 fall strobe (ratio=%0d ovr=%0d) %s", ratio, ovr, first_l);
    end

    // R7: first disabled edge clears everything
    en_i = 1'b0;
    @(negedge clk_i);
    check_bit("R7", "bclk after disable", bclk_o, 1'b0);
    check_bit("R7", "fclk after disable", fclk_o, 1'b0);
    check_bit("R7", "strobes after disable", bclk_rise_o | bclk_fall_o, 1'b0);
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    rst_ni  = 1'b0;
    en_i    = 1'b1;
    ratio_i = 12'd256;
    ovr_i   = 3'd0;
    repeat (4) @(negedge clk_i);
    // R1: reset holds outputs low even with enable high
    check_bit("R1", "bclk in reset", bclk_o, 1'b0);
    check_bit("R1", "fclk in reset", fclk_o, 1'b0);
    check_bit("R1", "strobes in reset", bclk_rise_o | bclk_fall_o, 1'b0);
    en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // automatic selection around the thresholds
    run_cfg(0,    0, "R4");
    run_cfg(191,  0, "R4");
    run_cfg(192,  0, "R4");
    run_cfg(256,  0, "R4");
    run_cfg(384,  0, "R4");
    run_cfg(385,  0, "R3");
    run_cfg(4095, 0, "R3");
    // every legal override code
    for (int c = 1; c < 8; c++) begin
      if (c != 4) run_cfg(500, c, "R9");
    end
    // illegal override code falls back to automatic
    run_cfg(100, 4, "R10");
    run_cfg(500, 4, "R10");
    run_cfg(300, 4, "R10");

    finish_run();
  end

endmodule